// File: doc/BRIEF.md
# Light-Load Burst Mode Controller

This block decides when a current-mode flyback controller leaves ordinary fixed-frequency PWM and drops into a low-power burst regime. It also decides when the controller returns. It sees the feedback voltage only as four digitized comparator flags: feedback low (under 1.35 V), above 3.0 V, above 3.5 V and above 4.0 V. It also receives a one-cycle tick from a microsecond time base.

A light load holds feedback low. If that lasts for a fixed blanking window (20 ms by default, counted in ticks), the block raises its burst flag and turns off the internal bias and switching. Inside burst, switching is gated by hysteresis. It resumes once feedback climbs above 3.5 V and stops once feedback is no longer above 3.0 V, so the output ripples in a sawtooth between the two levels. While burst is active, the block selects the reduced peak current limit and masks the high-VCC overvoltage check.

A sharp load step drives feedback above 4.0 V. This ends burst at once, restores the full current limit and returns the controller to normal PWM. A synchronous reset or a supply-undervoltage indication forces the normal state and clears the entry timer.

Top module: `lowload_burst_ctrl`

## Requirements
- R1: The entry timer is cleared in every cycle where `fb_lo_i` is 0. It advances by one only on cycles where `fb_lo_i` and `tick_i` are both 1, and saturates at ENTRY_TICKS.
- R2: `burst_o` rises one clock edge after the timer holds ENTRY_TICKS with `fb_lo_i` still 1. A release of `fb_lo_i` before that aborts the entry, and any later attempt needs a full ENTRY_TICKS again.
- R3: On entry into burst, `sw_en_o` (bias and switching enable) is 0.
- R4: In burst with switching off, `fb_hi35_i` = 1 (and no exit) sets `sw_en_o` to 1 after the next edge.
- R5: In burst with switching on, `fb_hi30_i` = 0 (and no exit) clears `sw_en_o` after the next edge. With `fb_hi30_i` = 1, switching stays on.
- R6: `ilim_low_o` (1 = reduced 0.34 V current limit, 0 = normal 1.03 V limit) equals `burst_o` at all times.
- R7: `ovp_mask_o` (1 = high-VCC overvoltage check masked) equals `burst_o` at all times.
- R8: `fb_hi40_i` = 1 during burst clears `burst_o` after the next edge, with `sw_en_o` = 1. This takes priority over the 3.5 V / 3.0 V gating in the same cycle.
- R9: After an exit from burst, the entry timer restarts from zero.
- R10: `rst` = 1 or `uvlo_i` = 1 forces `burst_o` = 0 and `sw_en_o` = 1 after the next edge, and clears the entry timer.
- R11: Outside burst, `sw_en_o` is 1 whatever `fb_hi30_i` and `fb_hi35_i` do.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| uvlo_i | input | 1 | Supply undervoltage indication, forces normal state |
| tick_i | input | 1 | One-cycle time-base pulse (1 us nominal) |
| fb_lo_i | input | 1 | Feedback below 1.35 V |
| fb_hi30_i | input | 1 | Feedback above 3.0 V |
| fb_hi35_i | input | 1 | Feedback above 3.5 V |
| fb_hi40_i | input | 1 | Feedback above 4.0 V |
| burst_o | output | 1 | Burst mode active |
| sw_en_o | output | 1 | Internal bias and switching enable |
| ilim_low_o | output | 1 | Select reduced peak current limit |
| ovp_mask_o | output | 1 | Mask the high-VCC overvoltage check |

## Verification
The bench builds the block with ENTRY_TICKS = 6 instead of 20000. This keeps the blanking window short enough to sweep every held-low tick count from zero to past saturation, which places the exact entry edge and the aborted entries within reach. With the short window, every feedback flag combination can be applied from both the switching-off and switching-on states inside burst. Full re-entry windows can also be repeated after exits, undervoltage and reset to show that the timer truly restarts.

// File: rtl/lowload_burst_pkg.sv
package lowload_burst_pkg;

  typedef enum logic [1:0] {
    ST_NORMAL     = 2'd0,
    ST_BURST_IDLE = 2'd1,
    ST_BURST_RUN  = 2'd2
  } burst_state_e;

  // Next regime from the current one and the feedback flags; exit wins.
  function automatic burst_state_e regime_next(
    input burst_state_e cur,
    input logic         entry_fire,
    input logic         hi30,
    input logic         hi35,
    input logic         hi40
  );
    burst_state_e nxt;
    nxt = cur;
    case (cur)
      ST_NORMAL:     if (entry_fire) nxt = ST_BURST_IDLE;
      ST_BURST_IDLE: if (hi40) nxt = ST_NORMAL;
                     else if (hi35) nxt = ST_BURST_RUN;
      ST_BURST_RUN:  if (hi40) nxt = ST_NORMAL;
                     else if (!hi30) nxt = ST_BURST_IDLE;
      default:       nxt = ST_NORMAL;
    endcase
    return nxt;
  endfunction

  function automatic logic in_burst(input burst_state_e s);
    return (s == ST_BURST_IDLE) || (s == ST_BURST_RUN);
  endfunction

endpackage

// File: rtl/burst_entry_timer.sv
module burst_entry_timer #(
  parameter int unsigned ENTRY_TICKS = 20000
) (
  input  logic clk,
  input  logic rst,
  input  logic clear_i,
  input  logic fb_lo_i,
  input  logic tick_i,
  output logic expired_o
);
  localparam int unsigned CNT_W = $clog2(ENTRY_TICKS + 1);
  localparam logic [CNT_W-1:0] LIMIT = CNT_W'(ENTRY_TICKS);

  logic [CNT_W-1:0] cnt_q;
  logic             at_limit;

  function automatic logic [CNT_W-1:0] count_step(
    input logic [CNT_W-1:0] c,
    input logic             hold_zero,
    input logic             tk
  );
    if (hold_zero) return '0;
    if (tk && (c != LIMIT)) return c + 1'b1;
    return c;
  endfunction

  always_ff @(posedge clk) begin
    if (rst) cnt_q <= '0;
    else     cnt_q <= count_step(cnt_q, clear_i || !fb_lo_i, tick_i);
  end

  assign at_limit  = (cnt_q == LIMIT);
  assign expired_o = fb_lo_i && at_limit;

  AST_TMR_HOLD_ZERO: assert property (@(posedge clk) disable iff (rst)
    (!fb_lo_i || clear_i) |=> (cnt_q == '0)); // R1
  AST_TMR_NO_TICK_STABLE: assert property (@(posedge clk) disable iff (rst)
    (fb_lo_i && !clear_i && !tick_i) |=> $stable(cnt_q)); // R1
  AST_TMR_BOUND: assert property (@(posedge clk) disable iff (rst)
    cnt_q <= LIMIT); // R2

endmodule

// File: rtl/burst_regime_fsm.sv
module burst_regime_fsm
  import lowload_burst_pkg::*;
(
  input  logic         clk,
  input  logic         rst,
  input  logic         uvlo_i,
  input  logic         entry_fire_i,
  input  logic         fb_hi30_i,
  input  logic         fb_hi35_i,
  input  logic         fb_hi40_i,
  output burst_state_e state_o
);
  burst_state_e state_q, state_d;

  always_comb begin
    if (uvlo_i) state_d = ST_NORMAL;
    else        state_d = regime_next(state_q, entry_fire_i,
                                      fb_hi30_i, fb_hi35_i, fb_hi40_i);
  end

  always_ff @(posedge clk) begin
    if (rst) state_q <= ST_NORMAL;
    else     state_q <= state_d;
  end

  assign state_o = state_q;

  AST_FSM_LEGAL: assert property (@(posedge clk) disable iff (rst)
    state_q != 2'd3); // R10
  AST_FSM_ENTRY_ONLY_IDLE: assert property (@(posedge clk) disable iff (rst)
    (state_q == ST_NORMAL) |=> (state_q != ST_BURST_RUN)); // R3

endmodule

// File: rtl/lowload_burst_ctrl.sv
module lowload_burst_ctrl
  import lowload_burst_pkg::*;
#(
  parameter int unsigned ENTRY_TICKS = 20000
) (
  input  logic clk,
  input  logic rst,
  input  logic uvlo_i,
  input  logic tick_i,
  input  logic fb_lo_i,
  input  logic fb_hi30_i,
  input  logic fb_hi35_i,
  input  logic fb_hi40_i,
  output logic burst_o,
  output logic sw_en_o,
  output logic ilim_low_o,
  output logic ovp_mask_o
);
  burst_state_e state;
  logic         entry_fire;
  logic         timer_clear;

  assign timer_clear = uvlo_i || in_burst(state);

  burst_entry_timer #(.ENTRY_TICKS(ENTRY_TICKS)) u_timer (
    .clk       (clk),
    .rst       (rst),
    .clear_i   (timer_clear),
    .fb_lo_i   (fb_lo_i),
    .tick_i    (tick_i),
    .expired_o (entry_fire)
  );

  burst_regime_fsm u_fsm (
    .clk          (clk),
    .rst          (rst),
    .uvlo_i       (uvlo_i),
    .entry_fire_i (entry_fire),
    .fb_hi30_i    (fb_hi30_i),
    .fb_hi35_i    (fb_hi35_i),
    .fb_hi40_i    (fb_hi40_i),
    .state_o      (state)
  );

  assign burst_o    = in_burst(state);
  assign sw_en_o    = (state != ST_BURST_IDLE);
  assign ilim_low_o = in_burst(state);
  assign ovp_mask_o = in_burst(state);

  AST_ENTRY_NEEDS_TIMER: assert property (@(posedge clk) disable iff (rst)
    $rose(burst_o) |-> $past(entry_fire)); // R2
  AST_ENTRY_SWITCH_OFF: assert property (@(posedge clk) disable iff (rst)
    $rose(burst_o) |-> !sw_en_o); // R3
  AST_WAKE_ON_HI35: assert property (@(posedge clk) disable iff (rst)
    (burst_o && !sw_en_o && fb_hi35_i && !fb_hi40_i && !uvlo_i) |=> (burst_o && sw_en_o)); // R4
  AST_SLEEP_BELOW_HI30: assert property (@(posedge clk) disable iff (rst)
    (burst_o && sw_en_o && !fb_hi30_i && !fb_hi40_i && !uvlo_i) |=> (burst_o && !sw_en_o)); // R5
  AST_ILIM_FOLLOWS: assert property (@(posedge clk) disable iff (rst)
    ilim_low_o == burst_o); // R6
  AST_OVP_MASK_FOLLOWS: assert property (@(posedge clk) disable iff (rst)
    ovp_mask_o == burst_o); // R7
  AST_EXIT_ON_HI40: assert property (@(posedge clk) disable iff (rst)
    (burst_o && fb_hi40_i) |=> (!burst_o && sw_en_o)); // R8
  AST_UVLO_FORCES_NORMAL: assert property (@(posedge clk) disable iff (rst)
    uvlo_i |=> (!burst_o && sw_en_o)); // R10
  AST_NORMAL_SWITCHING: assert property (@(posedge clk) disable iff (rst)
    !burst_o |-> sw_en_o); // R11

endmodule

// File: tb/lowload_burst_ctrl_bench.sv
module lowload_burst_ctrl_bench;
  localparam int unsigned N = 6;

  logic clk = 1'b0;
  logic rst, uvlo, tick, fb_lo, hi30, hi35, hi40;
  logic burst, sw_en, ilim_low, ovp_mask;
  int   n_total = 0;
  int   n_fail  = 0;
  bit   done    = 1'b0;

  always #2.5 clk = ~clk;

  lowload_burst_ctrl #(.ENTRY_TICKS(N)) u_lowload_burst_ctrl (
    .clk(clk), .rst(rst), .uvlo_i(uvlo), .tick_i(tick), .fb_lo_i(fb_lo),
    .fb_hi30_i(hi30), .fb_hi35_i(hi35), .fb_hi40_i(hi40),
    .burst_o(burst), .sw_en_o(sw_en), .ilim_low_o(ilim_low), .ovp_mask_o(ovp_mask)
  );

  task automatic step();
    @(posedge clk);
    #1;
  endtask

  task automatic chk(input logic act, input logic exp, input string tag);
    n_total++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%0b expected=%0b", tag, act, exp);
    end
  endtask

  task automatic do_tick();
    tick = 1'b1; step();
    tick = 1'b0; step();
  endtask

  task automatic enter_burst();
    fb_lo = 1'b1;
    for (int i = 0; i < N; i++) do_tick();
    fb_lo = 1'b0;
  endtask

  task automatic leave_burst();
    hi30 = 1'b1; hi35 = 1'b1; hi40 = 1'b1; step();
    hi30 = 1'b0; hi35 = 1'b0; hi40 = 1'b0;
  endtask

  task automatic finish_run();
    if (!done) begin
      done = 1'b1;
      $display("  %0d/%0d checks passed", n_total - n_fail, n_total);
      $finish;
    end
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    n_total++;
    n_fail++;
    $display("FAIL watchdog actual=timeout expected=completion");
    finish_run();
  end

  initial begin
    rst = 1'b1; uvlo = 1'b0; tick = 1'b0; fb_lo = 1'b0;
    hi30 = 1'b0; hi35 = 1'b0; hi40 = 1'b0;
    repeat (3) step();
    chk(burst, 1'b0, "R10 reset burst");
    chk(sw_en, 1'b1, "R10 reset sw_en");
    chk(ilim_low, 1'b0, "R6 reset ilim");
    chk(ovp_mask, 1'b0, "R7 reset ovp mask");
    rst = 1'b0;
    step();

    // R2 sweep over the number of ticks with feedback held low
    for (int k = 0; k <= N + 2; k++) begin
      fb_lo = 1'b1;
      for (int i = 0; i < k; i++) do_tick();
      step();
      chk(burst, (k >= N), $sformatf("R2 entry after %0d ticks", k));
      chk(sw_en, !(k >= N), $sformatf("R3 switching after %0d ticks", k));
      chk(ilim_low, (k >= N), $sformatf("R6 ilim after %0d ticks", k));
      chk(ovp_mask, (k >= N), $sformatf("R7 ovp mask after %0d ticks", k));
      fb_lo = 1'b0;
      if (k >= N) begin
        hi40 = 1'b1; step(); hi40 = 1'b0;
        chk(burst, 1'b0, "R8 exit after sweep entry");
      end else begin
        step();
      end
    end

    // R1 no ticks: timer must not advance
    fb_lo = 1'b1;
    repeat (3 * N) step();
    chk(burst, 1'b0, "R1 no tick no entry");
    fb_lo = 1'b0; step();

    // R2 abort by a feedback rise, then a fresh full window is needed
    fb_lo = 1'b1;
    for (int i = 0; i < N - 1; i++) do_tick();
    fb_lo = 1'b0; step();
    fb_lo = 1'b1;
    for (int i = 0; i < N - 1; i++) do_tick();
    step();
    chk(burst, 1'b0, "R2 aborted entry restarts");
    do_tick();
    chk(burst, 1'b1, "R1 entry after full window");
    fb_lo = 1'b0;
    leave_burst();

    // R4 R5 gating from both burst sub-states over all flag combinations
    for (int from_run = 0; from_run < 2; from_run++) begin
      for (int c = 0; c < 4; c++) begin
        enter_burst();
        if (from_run != 0) begin
          hi30 = 1'b1; hi35 = 1'b1; step();
          chk(sw_en, 1'b1, "R4 wake before sweep");
        end
        hi30 = c[0]; hi35 = c[1]; step();
        if (from_run != 0)
          chk(sw_en, c[0], $sformatf("R5 run state flags=%0d", c));
        else
          chk(sw_en, c[1], $sformatf("R4 idle state flags=%0d", c));
        chk(burst, 1'b1, $sformatf("R8 no exit without hi40 flags=%0d", c));
        hi40 = 1'b1; step(); hi40 = 1'b0; hi30 = 1'b0; hi35 = 1'b0;
        chk(burst, 1'b0, "R8 exit");
        chk(sw_en, 1'b1, "R8 exit switching");
        chk(ilim_low, 1'b0, "R6 full limit after exit");
      end
    end

    // R8 priority over the wake condition
    enter_burst();
    hi30 = 1'b1; hi35 = 1'b1; hi40 = 1'b1; step();
    chk(burst, 1'b0, "R8 exit beats wake");
    chk(sw_en, 1'b1, "R8 switching after priority exit");
    hi30 = 1'b0; hi35 = 1'b0; hi40 = 1'b0;

    // R9 timer restarts after exit
    fb_lo = 1'b1;
    for (int i = 0; i < N - 1; i++) do_tick();
    step();
    chk(burst, 1'b0, "R9 no early re-entry");
    do_tick();
    chk(burst, 1'b1, "R9 re-entry after full window");
    fb_lo = 1'b0;
    hi30 = 1'b1; hi35 = 1'b1; step();
    hi35 = 1'b0; hi30 = 1'b0; hi40 = 1'b1; step();
    chk(burst, 1'b0, "R8 exit beats sleep");
    chk(sw_en, 1'b1, "R8 switching after exit from run");
    hi40 = 1'b0;

    // R11 gating flags ignored outside burst
    for (int c = 0; c < 4; c++) begin
      hi30 = c[0]; hi35 = c[1]; step();
      chk(sw_en, 1'b1, $sformatf("R11 normal switching flags=%0d", c));
      chk(burst, 1'b0, $sformatf("R11 normal burst flags=%0d", c));
    end
    hi30 = 1'b0; hi35 = 1'b0;

    // R10 undervoltage forces normal and clears the timer
    enter_burst();
    hi30 = 1'b1; hi35 = 1'b1; step(); hi30 = 1'b0; hi35 = 1'b0;
    uvlo = 1'b1; step();
    chk(burst, 1'b0, "R10 uvlo burst");
    chk(sw_en, 1'b1, "R10 uvlo switching");
    chk(ovp_mask, 1'b0, "R7 uvlo ovp unmasked");
    fb_lo = 1'b1;
    for (int i = 0; i < N + 1; i++) do_tick();
    chk(burst, 1'b0, "R10 held during uvlo");
    uvlo = 1'b0;
    for (int i = 0; i < N - 1; i++) do_tick();
    step();
    chk(burst, 1'b0, "R10 timer cleared by uvlo");
    do_tick();
    chk(burst, 1'b1, "R10 entry after uvlo release");
    fb_lo = 1'b0;

    // R10 reset in burst
    rst = 1'b1; step();
    chk(burst, 1'b0, "R10 reset in burst");
    chk(sw_en, 1'b1, "R10 reset switching");
    rst = 1'b0; step();

    finish_run();
  end
endmodule